// File: doc/BRIEF.md
# Separator-Framing Byte Encoder

This block sits between a packet source and a byte-serial transmitter. Each packet arrives as a byte stream with valid/ready handshaking and an end-of-packet mark. The block frames the packet with a separator byte at both ends. A payload byte that would be mistaken for a separator, or for the escape marker, is sent as a two-byte escape pair, so a receiver can recover the frame boundaries and the original bytes without ambiguity.

The separator, the escape marker and the two codes that follow the marker are held in configuration registers. A single write strobe loads them, and reset returns them to their defaults. One input byte can become two output bytes. The block therefore lowers its input ready while it owes the second byte of a pair, and it does the same while a separator is still to be sent. The output is registered, and it holds steady under backpressure.

Top module: `sep_frame_encoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 0. The configuration registers hold separator 0xC0, escape marker 0xDB, separator code 0xDD and escape code 0xDC.
- R2: A frame opens with one separator byte. This byte is emitted before any byte of the packet. While the opening separator is still to be emitted, in_ready stays 0.
- R3: A payload byte that equals neither the separator nor the escape marker is emitted unchanged. Bytes keep their input order.
- R4: A payload byte equal to the separator is emitted as the escape marker followed by the separator code. If the separator and the escape marker are equal, this separator treatment takes precedence.
- R5: A payload byte equal to the escape marker is emitted as the escape marker followed by the escape code. A payload byte equal to either code passes unchanged.
- R6: In the cycle after an escaped byte is accepted, in_ready is 0. The next payload byte is taken only after the second byte of the pair has been loaded.
- R7: After the beat with in_last=1, one closing separator is emitted. in_ready stays 0 from the cycle after that beat until the closing separator has been loaded. The next packet starts a new frame with its own opening separator.
- R8: A beat with in_keep=0 carries no byte and emits nothing. When such a beat also has in_last=1, it ends the packet. A packet made only of that beat produces two adjacent separators.
- R9: While out_valid=1 and out_ready=0, out_valid stays 1 and out_data stays unchanged.
- R10: When cfg_we=1 on a clock edge, all four configuration values are loaded from their cfg_* inputs. The new values apply from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the four configuration values |
| cfg_sep | input | 8 | New separator byte |
| cfg_esc | input | 8 | New escape marker byte |
| cfg_code_sep | input | 8 | New code sent after the marker for an escaped separator |
| cfg_code_esc | input | 8 | New code sent after the marker for an escaped marker |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted on this edge when in_valid is 1 |
| in_data | input | 8 | Input payload byte |
| in_keep | input | 1 | 1 when in_data carries a byte |
| in_last | input | 1 | Last beat of the packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Encoded output byte |

## Verification
The bench runs the same set of packets twice, first with the output always ready and then under a repeating stall pattern, and it compares every framed byte. A design that escaped the codes themselves, missed the escape-marker case, or took a new input byte while it still owed the second byte of a pair would add, lose or reorder output bytes. Separate tests cover an empty packet, a no-byte beat in the middle of a packet, and new configuration values. A design that skipped a separator for an empty frame, emitted something for a no-byte beat, or kept using the old separator would fail the byte comparison. A reset in the middle of a frame must drop the partial frame and restore the default bytes.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BODY  = 2'd1,
    ST_ESC2  = 2'd2,
    ST_CLOSE = 2'd3
  } sfe_state_e;
endpackage

// File: rtl/sfe_cfg_regs.sv
module sfe_cfg_regs #(
  parameter int          W           = 8,
  parameter logic [W-1:0] DEF_SEP      = 8'hC0,
  parameter logic [W-1:0] DEF_ESC      = 8'hDB,
  parameter logic [W-1:0] DEF_CODE_SEP = 8'hDD,
  parameter logic [W-1:0] DEF_CODE_ESC = 8'hDC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] sep_d,
  input  logic [W-1:0] esc_d,
  input  logic [W-1:0] code_sep_d,
  input  logic [W-1:0] code_esc_d,
  output logic [W-1:0] sep_q,
  output logic [W-1:0] esc_q,
  output logic [W-1:0] code_sep_q,
  output logic [W-1:0] code_esc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sep_q      <= DEF_SEP;
      esc_q      <= DEF_ESC;
      code_sep_q <= DEF_CODE_SEP;
      code_esc_q <= DEF_CODE_ESC;
    end else if (we) begin
      sep_q      <= sep_d;
      esc_q      <= esc_d;
      code_sep_q <= code_sep_d;
      code_esc_q <= code_esc_d;
    end
  end
endmodule

// File: rtl/sfe_byte_classify.sv
module sfe_byte_classify #(
  parameter int W = 8
) (
  input  logic [W-1:0] byte_in,
  input  logic [W-1:0] sep,
  input  logic [W-1:0] esc,
  input  logic [W-1:0] code_sep,
  input  logic [W-1:0] code_esc,
  output logic         needs_esc,
  output logic [W-1:0] code
);
  logic is_sep;
  logic is_esc;

  assign is_sep    = (byte_in == sep);
  assign is_esc    = (byte_in == esc);
  assign needs_esc = is_sep | is_esc;
  // separator match wins when both configured bytes are equal
  assign code      = is_sep ? code_sep : code_esc;
endmodule

// File: rtl/sfe_out_reg.sv
module sfe_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         room
);
  assign room = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= load_data;
  end
endmodule

// File: rtl/sep_frame_encoder.sv
module sep_frame_encoder
  import sfe_pkg::*;
#(
  parameter int           W            = 8,
  parameter logic [W-1:0] DEF_SEP      = 8'hC0,
  parameter logic [W-1:0] DEF_ESC      = 8'hDB,
  parameter logic [W-1:0] DEF_CODE_SEP = 8'hDD,
  parameter logic [W-1:0] DEF_CODE_ESC = 8'hDC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_sep,
  input  logic [W-1:0] cfg_esc,
  input  logic [W-1:0] cfg_code_sep,
  input  logic [W-1:0] cfg_code_esc,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_keep,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [W-1:0] sep_q, esc_q, code_sep_q, code_esc_q;
  logic         needs_esc;
  logic [W-1:0] esc_code;
  logic         room;
  logic         load;
  logic [W-1:0] load_data;

  sfe_state_e   state, state_nxt;
  logic [W-1:0] pend_code;
  logic         pend_last;
  logic         take;

  sfe_cfg_regs #(
    .W(W), .DEF_SEP(DEF_SEP), .DEF_ESC(DEF_ESC),
    .DEF_CODE_SEP(DEF_CODE_SEP), .DEF_CODE_ESC(DEF_CODE_ESC)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we),
    .sep_d(cfg_sep), .esc_d(cfg_esc),
    .code_sep_d(cfg_code_sep), .code_esc_d(cfg_code_esc),
    .sep_q(sep_q), .esc_q(esc_q),
    .code_sep_q(code_sep_q), .code_esc_q(code_esc_q)
  );

  sfe_byte_classify #(.W(W)) u_cls (
    .byte_in(in_data), .sep(sep_q), .esc(esc_q),
    .code_sep(code_sep_q), .code_esc(code_esc_q),
    .needs_esc(needs_esc), .code(esc_code)
  );

  sfe_out_reg #(.W(W)) u_out (
    .clk(clk), .rst(rst), .load(load), .load_data(load_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .room(room)
  );

  assign in_ready = (state == ST_BODY) && room;
  assign take     = in_valid && in_ready;

  always_comb begin
    state_nxt = state;
    load      = 1'b0;
    load_data = sep_q;
    unique case (state)
      ST_IDLE: begin
        if (in_valid && room) begin
          load      = 1'b1;
          load_data = sep_q;
          state_nxt = ST_BODY;
        end
      end
      ST_BODY: begin
        if (take) begin
          if (in_keep) begin
            load = 1'b1;
            if (needs_esc) begin
              load_data = esc_q;
              state_nxt = ST_ESC2;
            end else begin
              load_data = in_data;
              if (in_last) state_nxt = ST_CLOSE;
            end
          end else if (in_last) begin
            state_nxt = ST_CLOSE;
          end
        end
      end
      ST_ESC2: begin
        if (room) begin
          load      = 1'b1;
          load_data = pend_code;
          state_nxt = pend_last ? ST_CLOSE : ST_BODY;
        end
      end
      ST_CLOSE: begin
        if (room) begin
          load      = 1'b1;
          load_data = sep_q;
          state_nxt = ST_IDLE;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_code <= '0;
      pend_last <= 1'b0;
    end else if (take && in_keep && needs_esc) begin
      pend_code <= esc_code;
      pend_last <= in_last;
    end
  end
endmodule

// File: rtl/sep_frame_encoder_chk.sv
module sep_frame_encoder_chk #(
  parameter int           W       = 8,
  parameter logic [W-1:0] DEF_SEP = 8'hC0,
  parameter logic [W-1:0] DEF_ESC = 8'hDB
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_we,
  input logic [W-1:0] cfg_sep,
  input logic [W-1:0] cfg_esc,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         in_keep,
  input logic         in_last,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  logic [W-1:0] sh_sep, sh_esc;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_sep <= DEF_SEP;
      sh_esc <= DEF_ESC;
    end else if (cfg_we) begin
      sh_sep <= cfg_sep;
      sh_esc <= cfg_esc;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid); // R9
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_data)); // R9
  AST_ESC_STALL: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_keep && (in_data == sh_sep || in_data == sh_esc) |=> !in_ready); // R6
  AST_CLOSE_STALL: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_last |=> !in_ready); // R7
  AST_NO_IDLE_TAKE: assert property (@(posedge clk) disable iff (rst)
    !out_valid && !in_ready |=> !(out_valid && in_ready && !$past(in_valid))); // R2
endmodule

bind sep_frame_encoder sep_frame_encoder_chk #(.W(W), .DEF_SEP(DEF_SEP), .DEF_ESC(DEF_ESC)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sep(cfg_sep), .cfg_esc(cfg_esc),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_keep(in_keep),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sep_frame_encoder_bench.sv
module sep_frame_encoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_sep = 8'h00, cfg_esc = 8'h00, cfg_code_sep = 8'h00, cfg_code_esc = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_keep = 1'b0;
  logic       in_last = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic bp = 1'b0;

  logic [7:0] cap [0:63];
  int         cap_n = 0;
  logic [7:0] exp_buf [0:31];

  // beat = {data, keep, last}
  localparam int NBEAT = 11;
  localparam logic [9:0] BEATS [NBEAT] = '{
    {8'h11, 2'b10}, {8'hC0, 2'b10}, {8'h22, 2'b11},
    {8'hDB, 2'b11},
    {8'h00, 2'b01},
    {8'h33, 2'b10}, {8'h00, 2'b00}, {8'hC0, 2'b11},
    {8'hDD, 2'b10}, {8'hDC, 2'b10}, {8'h44, 2'b11}
  };
  localparam int NEXP = 22;
  localparam logic [7:0] EXP_TBL [NEXP] = '{
    8'hC0, 8'h11, 8'hDB, 8'hDD, 8'h22, 8'hC0,
    8'hC0, 8'hDB, 8'hDC, 8'hC0,
    8'hC0, 8'hC0,
    8'hC0, 8'h33, 8'hDB, 8'hDD, 8'hC0,
    8'hC0, 8'hDD, 8'hDC, 8'h44, 8'hC0
  };

  sep_frame_encoder u_sep_frame_encoder (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sep(cfg_sep), .cfg_esc(cfg_esc),
    .cfg_code_sep(cfg_code_sep), .cfg_code_esc(cfg_code_esc),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_keep(in_keep), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) out_ready = bp ? ((cyc % 3) != 2) : 1'b1;

  always @(negedge clk) begin
    #1;
    if (!rst && out_valid && out_ready && cap_n < 64) begin
      cap[cap_n] = out_data;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_beat(input logic [7:0] d, input logic k, input logic l);
    in_data = d; in_keep = k; in_last = l; in_valid = 1'b1;
    do begin
      @(negedge clk); #1;
    end while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  task automatic compare(input string req, input int n);
    chk({req, " count"}, cap_n, n);
    for (int i = 0; i < n; i++) chk(req, cap[i], exp_buf[i]);
  endtask

  task automatic run_table(input string req);
    cap_n = 0;
    for (int i = 0; i < NBEAT; i++) send_beat(BEATS[i][9:2], BEATS[i][1], BEATS[i][0]);
    drain();
    for (int i = 0; i < NEXP; i++) exp_buf[i] = EXP_TBL[i];
    compare(req, NEXP);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 0);

    // R2: ready stays low while the opening separator is pending
    in_data = 8'h5A; in_keep = 1'b1; in_last = 1'b1; in_valid = 1'b1;
    out_ready = 1'b1;
    #0;
    chk("R2 in_ready before opening separator", in_ready, 0);
    @(posedge clk); #1;
    chk("R2 opening separator byte", out_data, 8'hC0);
    in_valid = 1'b0;
    send_beat(8'h5A, 1'b1, 1'b1);
    drain();
    cap_n = 0;

    // R3 R4 R5 R7 R8 with a free-running output
    run_table("R3 R4 R5 R7 R8 table, no stall");
    // R6 R9 under backpressure
    bp = 1'b1;
    run_table("R6 R9 table, stalled output");
    bp = 1'b0;

    // R10: new configuration
    @(negedge clk);
    cfg_sep = 8'h7E; cfg_esc = 8'h7D; cfg_code_sep = 8'h5E; cfg_code_esc = 8'h5D;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    cap_n = 0;
    send_beat(8'h7E, 1'b1, 1'b0);
    send_beat(8'h7D, 1'b1, 1'b0);
    send_beat(8'hC0, 1'b1, 1'b1);
    drain();
    exp_buf[0] = 8'h7E; exp_buf[1] = 8'h7D; exp_buf[2] = 8'h5E; exp_buf[3] = 8'h7D;
    exp_buf[4] = 8'h5D; exp_buf[5] = 8'hC0; exp_buf[6] = 8'h7E;
    compare("R10 reconfigured frame", 7);

    // R8: empty packet under stall, with new separator
    bp = 1'b1;
    cap_n = 0;
    send_beat(8'h00, 1'b0, 1'b1);
    drain();
    exp_buf[0] = 8'h7E; exp_buf[1] = 8'h7E;
    compare("R8 empty frame", 2);
    bp = 1'b0;

    // R1: reset mid-frame restores defaults and drops the frame
    send_beat(8'h55, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 out_valid after mid-frame reset", out_valid, 0);
    cap_n = 0;
    send_beat(8'hC0, 1'b1, 1'b1);
    drain();
    exp_buf[0] = 8'hC0; exp_buf[1] = 8'hDB; exp_buf[2] = 8'hDD; exp_buf[3] = 8'hC0;
    compare("R1 default bytes after reset", 4);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule